// File: doc/BRIEF.md
# Bit-level pipelined ripple-carry adder

This block adds two unsigned operands and a carry input. It is built as a ripple-carry chain in which a register follows every full-adder cell. No logic path between registers crosses more than one full adder, so the clock period is set by a single cell rather than by the whole chain. The block accepts one operand pair on every clock edge and produces one result per clock, with a latency of WIDTH-1 cycles.

Bit i of each operand is delayed by i registers before it meets its cell. It therefore reaches that cell in the same cycle as the carry produced by bit i-1 of the same pair. Each finished sum bit is then held by WIDTH-1-i registers, so all sum bits and the carry out of one pair leave together. A valid flag moves alongside the data with the same latency. Only that flag is cleared by the synchronous reset. The data registers never reset.

Top module: `pipelined_rca`

## Requirements
- R1: While `rst` is high at a rising edge, every stage of the valid pipeline clears. From the next cycle on, `out_valid` stays low until a pair marked valid after reset release has crossed all WIDTH-1 stages.
- R2: The pair sampled at rising edge k appears on `{carry_out, sum_out}` in the cycle after edge k+WIDTH-2, as the (WIDTH+1)-bit unsigned sum a+b+carry_in. This is a latency of 3 cycles at WIDTH=4.
- R3: `out_valid` repeats the `in_valid` value sampled with the same pair, with the same latency as the data.
- R4: A new operand pair can be applied on every clock, with no stall. Back-to-back pairs each produce their own correct result in order.
- R5: The carry ripples across every bit position. For example, an all-ones a with b=0 and carry_in=1 gives sum 0 and carry_out 1, and an all-ones a and b with carry_in=1 gives an all-ones sum with carry_out 1.
- R6: The arithmetic does not depend on `in_valid`. Pairs applied with `in_valid` low still produce correct sums.
- R7: Reset does not disturb the data path. A pair applied while `rst` is high still emerges with the correct sum after the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline only |
| in_valid | input | 1 | Marks the operand pair on this cycle as meaningful |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Valid flag aligned with the result |
| sum_out | output | WIDTH | Sum bits, all from the same pair |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder with WIDTH=4, which gives three cut-set stages. At this width all 512 combinations of a, b and carry_in can be swept exhaustively, so every carry-ripple pattern through the skew and deskew alignment is covered. Random back-to-back traffic with a random valid flag follows the sweep. Reset pulses are placed both at start-up and in the middle of a stream, so the valid flush and the data that passes through during reset are both exercised.

// File: rtl/rca_pipe_pkg.sv
package rca_pipe_pkg;

  typedef struct packed {
    logic sum_bit;
    logic carry_bit;
  } fa_out_t;

  // One-bit full adder: the only arithmetic between any two registers.
  function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
    fa_out_t r;
    r.sum_bit   = x ^ y ^ ci;
    r.carry_bit = (x & y) | (ci & (x ^ y));
    return r;
  endfunction

endpackage

// File: rtl/rca_delay_line.sv
// Plain shift register of DEPTH stages, no reset (data alignment only).
module rca_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rca_valid_pipe.sv
// Valid flag delay with synchronous clear of every stage.
module rca_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rca_fa_cell.sv
module rca_fa_cell
  import rca_pipe_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  fa_out_t res;
  assign res = full_add(x_i, y_i, c_i);
  assign s_o = res.sum_bit;
  assign c_o = res.carry_bit;
endmodule

// File: rtl/pipelined_rca.sv
module pipelined_rca #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int LAT = WIDTH - 1;

  // Per-stage carry into, sum out of and carry out of each cell.
  logic [WIDTH-1:0] stage_cin;
  logic [WIDTH-1:0] stage_sum;
  logic [WIDTH-1:0] stage_cout;

  assign stage_cin[0] = carry_in;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [1:0] ops;

      // Skew: bit i waits i cycles for the carry of its own pair.
      rca_delay_line #(.W(2), .DEPTH(i)) u_skew (
        .clk(clk),
        .d  ({a_in[i], b_in[i]}),
        .q  (ops)
      );

      rca_fa_cell u_fa (
        .x_i(ops[1]),
        .y_i(ops[0]),
        .c_i(stage_cin[i]),
        .s_o(stage_sum[i]),
        .c_o(stage_cout[i])
      );

      // Deskew: early sum bits wait for the last stage.
      rca_delay_line #(.W(1), .DEPTH(LAT - i)) u_deskew (
        .clk(clk),
        .d  (stage_sum[i]),
        .q  (sum_out[i])
      );

      if (i < WIDTH - 1) begin : g_cut
        logic carry_q;
        always_ff @(posedge clk) carry_q <= stage_cout[i];
        assign stage_cin[i+1] = carry_q;
      end else begin : g_tail
        assign carry_out = stage_cout[i];
      end
    end
  endgenerate

  rca_valid_pipe #(.DEPTH(LAT)) u_vld (
    .clk(clk),
    .rst(rst),
    .d  (in_valid),
    .q  (out_valid)
  );

endmodule

// File: rtl/pipelined_rca_checker.sv
// Assertions for pipelined_rca; expects WIDTH >= 2.
module pipelined_rca_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             carry_in,
  input logic             out_valid,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);
  localparam int LAT = WIDTH - 1;

  // Reference result and valid flag, delayed by a counter-free shift line.
  logic [WIDTH:0] exp_dl [LAT];
  logic           vin_dl [LAT];
  int unsigned    since_rst;

  always_ff @(posedge clk) begin
    exp_dl[0] <= {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};
    vin_dl[0] <= in_valid;
    for (int k = 1; k < LAT; k++) begin
      exp_dl[k] <= exp_dl[k-1];
      vin_dl[k] <= vin_dl[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < LAT) since_rst <= since_rst + 1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (since_rst < LAT) |-> !out_valid);

  a_r2_sum_matches: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LAT) |-> ({carry_out, sum_out} == exp_dl[LAT-1]));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LAT) |-> (out_valid == vin_dl[LAT-1]));

  a_r6_result_known: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= LAT) |-> !$isunknown({carry_out, sum_out}));

endmodule

bind pipelined_rca pipelined_rca_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .carry_in(carry_in), .out_valid(out_valid), .sum_out(sum_out),
  .carry_out(carry_out)
);

// File: tb/pipelined_rca_test.sv
module pipelined_rca_test;
  localparam int W   = 4;
  localparam int LAT = W - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         carry_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int checks = 0;
  int fails  = 0;
  int n      = 0;

  logic [W-1:0] ha [8];
  logic [W-1:0] hb [8];
  logic         hc [8];
  logic         hv [8];
  logic         hr [8];
  string        htag [8];

  always #4 clk = ~clk;

  pipelined_rca #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
    .carry_in(carry_in), .out_valid(out_valid), .sum_out(sum_out),
    .carry_out(carry_out)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    int unsigned t;
    t = int'(x) + int'(y) + (c ? 1 : 0);
    return t[W:0];
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Each step: observe outputs for the pair driven LAT steps ago, then drive.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                      input logic v, input logic r, input string tag);
    @(negedge clk);
    if (n >= LAT) begin
      int i0;
      logic exp_v;
      logic rst_seen;
      i0 = (n - LAT) % 8;
      check(htag[i0], {carry_out, sum_out}, ref_add(ha[i0], hb[i0], hc[i0]));
      rst_seen = 1'b0;
      for (int k = n - LAT; k < n; k++) rst_seen |= hr[k % 8];
      exp_v = hv[i0] & ~rst_seen;
      check(rst_seen ? "R1" : "R3", {{W{1'b0}}, out_valid}, {{W{1'b0}}, exp_v});
    end
    a_in = a; b_in = b; carry_in = c; in_valid = v; rst = r;
    ha[n % 8] = a; hb[n % 8] = b; hc[n % 8] = c; hv[n % 8] = v; hr[n % 8] = r;
    htag[n % 8] = tag;
    n++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));

    // R7: data applied during reset still emerges; R1: valid stays clear.
    step(4'h3, 4'h5, 1'b1, 1'b1, 1'b1, "R7");
    step(4'hF, 4'h1, 1'b0, 1'b1, 1'b1, "R7");
    step(4'h9, 4'h9, 1'b1, 1'b1, 1'b1, "R7");
    // R1: reset state at the port.
    check("R1", {{W{1'b0}}, out_valid}, '0);
    // R6: in_valid low, arithmetic unaffected.
    step(4'h7, 4'h8, 1'b1, 1'b0, 1'b0, "R6");
    step(4'hA, 4'h6, 1'b0, 1'b0, 1'b0, "R6");
    // R5: full carry ripple corners.
    step(4'hF, 4'h0, 1'b1, 1'b1, 1'b0, "R5");
    step(4'hF, 4'hF, 1'b1, 1'b1, 1'b0, "R5");
    step(4'h0, 4'h0, 1'b0, 1'b1, 1'b0, "R5");
    step(4'h8, 4'h8, 1'b0, 1'b1, 1'b0, "R5");
    step(4'h0, 4'hF, 1'b1, 1'b1, 1'b0, "R5");
    // R2: exhaustive sweep.
    for (int x = 0; x < 512; x++)
      step(x[3:0], x[7:4], x[8], 1'b1, 1'b0, "R2");
    // R4: random back-to-back, random valid flag.
    for (int j = 0; j < 1500; j++)
      step($urandom, $urandom, $urandom, $urandom, 1'b0, "R4");
    // R1/R7: reset pulse in the middle of a stream.
    step(4'hC, 4'h4, 1'b1, 1'b1, 1'b1, "R7");
    for (int j = 0; j < 40; j++)
      step($urandom, $urandom, $urandom, 1'b1, 1'b0, "R4");
    // Flush.
    for (int j = 0; j < LAT; j++)
      step('0, '0, 1'b0, 1'b0, 1'b0, "R2");
    @(negedge clk);
    summary();
    $finish;
  end
endmodule